// File: doc/BRIEF.md
# Priority Service Queue Scheduler

This block decides which per-flow queue is served next. Each flow is assigned one of four priority levels. A flow that holds data waits in the service list for its level. Each service list is a singly linked list of flow numbers, tracked by a head register and a tail register, with one shared next-pointer table. Packet storage lies outside this block. The block only orders the flow numbers.

When the surrounding queue manager reports that a flow has become non-empty, that flow is appended to its level's list, unless it is already present. On a service request, the block takes the head flow from the most urgent non-empty list and presents it for one cycle. In that same cycle the queue manager reports whether the flow still holds data. A flow that still holds data goes back to the tail of its own list. An exhausted flow leaves the lists. Flows that share a level are therefore served in rotation, and a lower level is served only while every more urgent list is empty.

Top module: `prio_flow_sched`

## Requirements
- R1: After a synchronous active-low reset, every service list is empty and no flow is linked. `sel_valid` is 0, and a service request then produces no selection.
- R2: A write with `cfg_we` sets the level of flow `cfg_flow` to `cfg_lvl`. Level 0 is the most urgent and level 3 the least. Every flow starts at level 3 after reset. The write is ignored while that flow is linked (waiting or in service) and also in the cycle its non-empty event is accepted.
- R3: A non-empty event (`ne_valid`, `ne_flow`) for an unlinked flow appends that flow at the tail of the list for its current level.
- R4: A non-empty event for a flow that is already linked, including the flow in service, is ignored, so a flow is never listed twice.
- R5: A service request accepted at a clock edge makes `sel_valid` 1 in the following cycle. In that cycle `sel_flow` is the head of the lowest-numbered non-empty list and `sel_lvl` is that list's level. The flow is removed from the list.
- R6: A service request is ignored when all lists are empty or when `sel_valid` is 1. `sel_valid` is then 0 in the next cycle.
- R7: If `svc_more` is 1 during the `sel_valid` cycle, the selected flow is appended at the tail of the list it came from. When a non-empty event is accepted at the same edge, the re-entry is placed ahead of it. Flows of one level are therefore served in rotation.
- R8: If `svc_more` is 0 during the `sel_valid` cycle, the selected flow becomes unlinked. A later non-empty event links it again.
- R9: `sel_valid` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Level configuration write strobe |
| cfg_flow | input | 4 | Flow whose level is written |
| cfg_lvl | input | 2 | New level, 0 most urgent |
| ne_valid | input | 1 | Flow-became-non-empty event |
| ne_flow | input | 4 | Flow of the non-empty event |
| svc_req | input | 1 | Request for the next flow to serve |
| svc_more | input | 1 | During the selection cycle: selected flow still holds data |
| sel_valid | output | 1 | Selection present this cycle |
| sel_flow | output | 4 | Selected flow |
| sel_lvl | output | 2 | Level the selected flow was taken from |

## Verification
A damaged next pointer or a stale head register appears at the ports in the very next selection as a wrong flow number. It may also appear later as a flow that is served twice in one rotation or never served again. A wrong non-empty flag for a list shows up as a less urgent level being served, or as a selection while nothing is linked. The bench therefore keeps its own list model and compares every selection cycle, so any such fault is reported within one request of when it takes effect.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // index of the lowest set bit of v within the first n bits (0 when none)
  function automatic int first_set(input logic [31:0] v, input int n);
    first_set = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) first_set = i;
    end
  endfunction
endpackage

// File: rtl/sq_pick.sv
module sq_pick #(
  parameter int NLVL = 4,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic [NLVL-1:0] q_ne,
  output logic            any_ne,
  output logic [LW-1:0]   pick_lvl
);
  import sq_pkg::*;
  assign any_ne   = |q_ne;
  assign pick_lvl = LW'(first_set(32'(q_ne), NLVL));
endmodule

// File: rtl/sq_flow_tbl.sv
module sq_flow_tbl #(
  parameter int NFLOW = 16,
  parameter int NLVL  = 4,
  localparam int FW = $clog2(NFLOW),
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [FW-1:0]    cfg_flow,
  input  logic [LW-1:0]    cfg_lvl,
  input  logic             ne_valid,
  input  logic [FW-1:0]    ne_flow,
  input  logic             drop_v,
  input  logic [FW-1:0]    drop_flow,
  input  logic [FW-1:0]    look_flow,
  output logic             ne_accept,
  output logic [LW-1:0]    ne_lvl,
  output logic [LW-1:0]    look_lvl,
  output logic [NFLOW-1:0] linked
);
  logic [LW-1:0]    prio_q [NFLOW];
  logic [NFLOW-1:0] linked_q;
  logic             cfg_ok;

  assign ne_accept = ne_valid && !linked_q[ne_flow];
  assign ne_lvl    = prio_q[ne_flow];
  assign look_lvl  = prio_q[look_flow];
  assign linked    = linked_q;
  assign cfg_ok    = cfg_we && !linked_q[cfg_flow] && !(ne_accept && ne_flow == cfg_flow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      linked_q <= '0;
      for (int i = 0; i < NFLOW; i++) prio_q[i] <= LW'(NLVL - 1);
    end else begin
      if (drop_v) linked_q[drop_flow] <= 1'b0;
      if (ne_accept) linked_q[ne_flow] <= 1'b1;
      if (cfg_ok) prio_q[cfg_flow] <= cfg_lvl;
    end
  end

  // a duplicate non-empty event never reaches the lists
  p_dup_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ne_valid && linked_q[ne_flow]) |-> !ne_accept);

  // level of a linked flow is frozen
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && linked_q[cfg_flow]) |=> prio_q[$past(cfg_flow)] == $past(prio_q[cfg_flow]));
endmodule

// File: rtl/sq_lists.sv
module sq_lists #(
  parameter int NFLOW = 16,
  parameter int NLVL  = 4,
  localparam int FW = $clog2(NFLOW),
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  input  logic [LW-1:0]   pop_lvl,
  input  logic            app1_v,
  input  logic [FW-1:0]   app1_flow,
  input  logic [LW-1:0]   app1_lvl,
  input  logic            app2_v,
  input  logic [FW-1:0]   app2_flow,
  input  logic [LW-1:0]   app2_lvl,
  output logic [FW-1:0]   front,
  output logic [NLVL-1:0] q_ne
);
  logic [FW-1:0]   head_q [NLVL];
  logic [FW-1:0]   tail_q [NLVL];
  logic [FW-1:0]   nxt_q  [NFLOW];
  logic [NLVL-1:0] ne_q;
  logic [FW-1:0]   head_d [NLVL];
  logic [FW-1:0]   tail_d [NLVL];
  logic [FW-1:0]   nxt_d  [NFLOW];
  logic [NLVL-1:0] ne_d;

  assign front = head_q[pop_lvl];
  assign q_ne  = ne_q;

  // removal first, then the re-entry, then the new arrival
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    nxt_d  = nxt_q;
    ne_d   = ne_q;
    if (pop) begin
      if (head_q[pop_lvl] == tail_q[pop_lvl]) ne_d[pop_lvl] = 1'b0;
      else head_d[pop_lvl] = nxt_q[head_q[pop_lvl]];
    end
    if (app1_v) begin
      if (ne_d[app1_lvl]) nxt_d[tail_d[app1_lvl]] = app1_flow;
      else head_d[app1_lvl] = app1_flow;
      tail_d[app1_lvl] = app1_flow;
      ne_d[app1_lvl]   = 1'b1;
    end
    if (app2_v) begin
      if (ne_d[app2_lvl]) nxt_d[tail_d[app2_lvl]] = app2_flow;
      else head_d[app2_lvl] = app2_flow;
      tail_d[app2_lvl] = app2_flow;
      ne_d[app2_lvl]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ne_q <= '0;
      for (int l = 0; l < NLVL; l++) begin
        head_q[l] <= '0;
        tail_q[l] <= '0;
      end
      for (int f = 0; f < NFLOW; f++) nxt_q[f] <= '0;
    end else begin
      ne_q   <= ne_d;
      head_q <= head_d;
      tail_q <= tail_d;
      nxt_q  <= nxt_d;
    end
  end

  // only an occupied list is ever popped
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ne_q[pop_lvl]);
endmodule

// File: rtl/prio_flow_sched.sv
module prio_flow_sched #(
  parameter int NFLOW = 16,
  parameter int NLVL  = 4,
  localparam int FW = $clog2(NFLOW),
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [FW-1:0] cfg_flow,
  input  logic [LW-1:0] cfg_lvl,
  input  logic          ne_valid,
  input  logic [FW-1:0] ne_flow,
  input  logic          svc_req,
  input  logic          svc_more,
  output logic          sel_valid,
  output logic [FW-1:0] sel_flow,
  output logic [LW-1:0] sel_lvl
);
  logic             any_ne;
  logic [LW-1:0]    pick_lvl;
  logic [NLVL-1:0]  q_ne;
  logic [FW-1:0]    front;
  logic             pop;
  logic             ne_accept;
  logic [LW-1:0]    ne_lvl;
  logic [LW-1:0]    cur_lvl;
  logic [NFLOW-1:0] linked;
  logic             reenter;
  logic             drop;

  assign pop     = svc_req && !sel_valid && any_ne;
  assign reenter = sel_valid && svc_more;
  assign drop    = sel_valid && !svc_more;

  sq_pick #(.NLVL(NLVL)) u_pick (
    .q_ne(q_ne), .any_ne(any_ne), .pick_lvl(pick_lvl)
  );

  sq_flow_tbl #(.NFLOW(NFLOW), .NLVL(NLVL)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_lvl(cfg_lvl),
    .ne_valid(ne_valid), .ne_flow(ne_flow),
    .drop_v(drop), .drop_flow(sel_flow),
    .look_flow(sel_flow),
    .ne_accept(ne_accept), .ne_lvl(ne_lvl), .look_lvl(cur_lvl),
    .linked(linked)
  );

  sq_lists #(.NFLOW(NFLOW), .NLVL(NLVL)) u_lists (
    .clk(clk), .rst_n(rst_n),
    .pop(pop), .pop_lvl(pick_lvl),
    .app1_v(reenter), .app1_flow(sel_flow), .app1_lvl(sel_lvl),
    .app2_v(ne_accept), .app2_flow(ne_flow), .app2_lvl(ne_lvl),
    .front(front), .q_ne(q_ne)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_flow  <= '0;
      sel_lvl   <= '0;
    end else begin
      sel_valid <= pop;
      if (pop) begin
        sel_flow <= front;
        sel_lvl  <= pick_lvl;
      end
    end
  end

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> !sel_valid);

  p_empty_no_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_ne == '0) |=> !sel_valid);

  p_sel_linked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> linked[sel_flow]);

  p_same_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> cur_lvl == sel_lvl);

  p_most_urgent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (q_ne & ((NLVL'(1) << pick_lvl) - NLVL'(1))) == '0);
endmodule

// File: tb/prio_flow_sched_test.sv
module prio_flow_sched_test;
  localparam int NF = 16;
  localparam int NL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_flow = '0;
  logic [1:0] cfg_lvl = '0;
  logic       ne_valid = 1'b0;
  logic [3:0] ne_flow = '0;
  logic       svc_req = 1'b0;
  logic       svc_more = 1'b0;
  logic       sel_valid;
  logic [3:0] sel_flow;
  logic [1:0] sel_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference model
  int mq [NL][NF];
  int mcnt [NL];
  bit mlink [NF];
  int mprio [NF];
  bit exp_v = 0;
  int exp_f = 0;
  int exp_l = 0;

  always #4 clk = ~clk;

  prio_flow_sched uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_lvl(cfg_lvl),
    .ne_valid(ne_valid), .ne_flow(ne_flow), .svc_req(svc_req), .svc_more(svc_more),
    .sel_valid(sel_valid), .sel_flow(sel_flow), .sel_lvl(sel_lvl)
  );

  function automatic int lowest_busy();
    for (int l = 0; l < NL; l++) if (mcnt[l] > 0) return l;
    return -1;
  endfunction

  task automatic model_push(input int l, input int f);
    mq[l][mcnt[l]] = f;
    mcnt[l]++;
  endtask

  task automatic check(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NL; l++) mcnt[l] = 0;
    for (int f = 0; f < NF; f++) begin
      mlink[f] = 0;
      mprio[f] = NL - 1;
    end
    exp_v = 0;
  endtask

  // one cycle: drive at negedge, update model, check after the edge
  task automatic step(input bit cw, input int cf, input int cl, input bit nv, input int nf,
                      input bit rq, input bit more);
    bit pre [NF];
    bit acc;
    bit nv_new;
    int nf_new;
    int nl_new;
    int lv;
    cfg_we = cw; cfg_flow = 4'(cf); cfg_lvl = 2'(cl);
    ne_valid = nv; ne_flow = 4'(nf);
    svc_req = rq; svc_more = more;
    pre = mlink;
    acc = nv && !mlink[nf];
    nv_new = 0; nf_new = 0; nl_new = 0;
    lv = lowest_busy();
    if (rq && !exp_v && lv >= 0) begin
      nv_new = 1;
      nf_new = mq[lv][0];
      nl_new = lv;
      for (int i = 1; i < mcnt[lv]; i++) mq[lv][i-1] = mq[lv][i];
      mcnt[lv]--;
    end
    if (exp_v) begin
      if (more) model_push(exp_l, exp_f);
      else mlink[exp_f] = 0;
    end
    if (acc) begin
      model_push(mprio[nf], nf);
      mlink[nf] = 1;
    end
    if (cw && !pre[cf] && !(acc && nf == cf)) mprio[cf] = cl;
    exp_v = nv_new; exp_f = nf_new; exp_l = nl_new;
    @(posedge clk);
    @(negedge clk);
    check(tag, "sel_valid", int'(sel_valid), int'(exp_v));
    if (exp_v && sel_valid) begin
      check(tag, "sel_flow", int'(sel_flow), exp_f);
      check(tag, "sel_lvl", int'(sel_lvl), exp_l);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  // serve: request, then answer with more during the selection cycle
  task automatic serve(input bit more);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, more);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "sel_valid after reset", int'(sel_valid), 0);
    // R1: request on empty lists yields nothing
    tag = "R1";
    step(0, 0, 0, 0, 0, 1, 0);
    idle();

    // R2: levels configured while flows are unlinked
    tag = "R2";
    step(1, 3, 2, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0, 0);
    step(1, 7, 2, 0, 0, 0, 0);
    step(1, 9, 1, 0, 0, 0, 0);
    // R3: link flows
    tag = "R3";
    step(0, 0, 0, 1, 3, 0, 0);
    step(0, 0, 0, 1, 7, 0, 0);
    step(0, 0, 0, 1, 9, 0, 0);
    step(0, 0, 0, 1, 5, 0, 0);
    // R4: duplicate event, then a write to a linked flow (R2 ignore)
    tag = "R4";
    step(0, 0, 0, 1, 3, 0, 0);
    tag = "R2";
    step(1, 3, 0, 0, 0, 0, 0);
    // R5: most urgent first, flow 5 at level 0
    tag = "R5";
    serve(0);
    // R6: request during the selection cycle is ignored
    tag = "R6";
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    // R8: flow 9 dropped, then relinked by a new event
    tag = "R8";
    serve(0);
    step(0, 0, 0, 1, 9, 0, 0);
    serve(0);
    // R7: rotation between flows 3 and 7 at level 2
    tag = "R7";
    serve(1);
    serve(1);
    serve(1);
    // R7: re-entry and new arrival at the same edge, same level
    step(1, 11, 2, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 11, 0, 1);
    serve(1);
    serve(1);
    // R4: event for the flow in service is ignored
    tag = "R4";
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 1, exp_f, 0, 0);
    serve(0);
    serve(0);
    serve(0);
    // R9 and R5: back-to-back requests
    tag = "R9";
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, i, 1, 1);

    // random phase
    tag = "R5";
    for (int c = 0; c < 4000; c++) begin
      bit cw, nv, rq, mo;
      cw = ($urandom % 10) == 0;
      nv = ($urandom % 10) < 3;
      rq = ($urandom % 2) == 0;
      mo = ($urandom % 10) < 7;
      step(cw, int'($urandom % NF), int'($urandom % NL), nv, int'($urandom % NF), rq, mo);
    end

    // R1: reset in the middle empties everything
    tag = "R1";
    rst_n = 1'b0;
    cfg_we = 0; ne_valid = 0; svc_req = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    check("R1", "sel_valid after second reset", int'(sel_valid), 0);
    step(0, 0, 0, 0, 0, 1, 0);
    idle();
    step(0, 0, 0, 1, 4, 0, 0);
    serve(0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule